// File: doc/BRIEF.md
# Reorder Buffer for In-Order Commit

This block keeps the results of speculatively executed instructions in a circular queue until they can retire in program order. The issue stage claims a slot for each instruction and records its class (register write, store or branch) and its destination register. The slot index it gets back is the tag that the functional units later use to write the result value. Reservation stations can read a finished result through a lookup port instead of waiting for the functional unit. The result is read by tag, before the instruction retires.

Retirement takes the oldest slot only, and only once it holds a result. At most one slot retires per cycle. Register-writing entries drive the register-file write port at that point. Store entries raise a store-release pulse, and branch entries only retire. Architectural state is never touched before retirement. The branch unit can order a flush on a mispredicted branch. The flush throws away every slot younger than that branch in a single cycle. A fault reported by a functional unit is only recorded in its slot. It takes effect when that slot reaches the head: a trap pulse is raised, the destination is not written, and the whole queue is emptied.

Top module: `reorder_commit_buf`

## Requirements
- R1: Out of reset, `alloc_ok` is 1, `alloc_tag` is 0, and `rf_we`, `st_commit`, `cm_valid`, `trap` and `lk_ready` are all 0.
- R2: A request with `alloc_ok` high claims slot `alloc_tag`. Successive claims receive consecutive tags, modulo DEPTH. After DEPTH claims with no retirement, `alloc_ok` drops to 0 and a further request claims nothing.
- R3: A write-back to a live slot marks it ready and stores its value. From the next cycle, a lookup of that tag returns `lk_ready`=1 and the written value.
- R4: Slots retire strictly in claim order, one per cycle, and only once the head slot is ready. The retirement outputs appear one cycle after the head is seen ready. A ready slot behind an unready head does not retire.
- R5: Kind encoding is 00 = register write, 01 = store, 10 = branch. A retiring kind-00 slot raises `rf_we` with its destination and value. A kind-01 slot raises `st_commit` without `rf_we`. A kind-10 slot raises only `cm_valid`, and `cm_kind` reports the kind in every case.
- R6: `rf_we` and `st_commit` stay 0 while no slot retires, even if write-backs arrive.
- R7: With `flush_valid` high, `alloc_ok` is 0. On the next cycle the next tag handed out is `flush_tag`+1. Slots younger than `flush_tag` become dead, so a write-back to them leaves lookups showing not-ready, and older slots retire normally.
- R8: A fault flag written back on a slot causes no trap while an older slot is still outstanding.
- R9: When a faulting slot reaches the head and is ready, `trap` pulses with `trap_tag` equal to its tag. `rf_we` stays 0, every slot becomes dead, and the next tag handed out equals the faulting tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Issue stage requests a slot |
| alloc_kind | input | 2 | Class of the issuing instruction (00 reg, 01 store, 10 branch) |
| alloc_dest | input | RAW | Destination register number |
| alloc_ok | output | 1 | A request this cycle is accepted |
| alloc_tag | output | IDXW | Slot index given to the request |
| wb_valid | input | 1 | Functional unit result write-back |
| wb_tag | input | IDXW | Slot the result belongs to |
| wb_value | input | XLEN | Result value |
| wb_exc | input | 1 | Result carries a fault |
| flush_valid | input | 1 | Branch misprediction flush |
| flush_tag | input | IDXW | Slot of the mispredicted branch |
| lk_tag | input | IDXW | Operand lookup tag |
| lk_ready | output | 1 | Looked-up slot is live and holds its result |
| lk_value | output | XLEN | Looked-up result value |
| rf_we | output | 1 | Register-file write at retirement |
| rf_waddr | output | RAW | Register-file write address |
| rf_wdata | output | XLEN | Register-file write data |
| st_commit | output | 1 | A store retires and may be released to memory |
| cm_valid | output | 1 | A slot retired without fault |
| cm_kind | output | 2 | Kind of the retired slot |
| trap | output | 1 | A faulting slot reached retirement |
| trap_tag | output | IDXW | Tag of the faulting slot |

## Verification
Claim, lookup and flush-blocking results are combinational and are checked shortly after the inputs are driven, before the next rising edge. A write-back takes effect at the next edge, so lookups are checked at the falling edge that follows. Retirement outputs are registered, so they show two edges after the write-back that made the head ready, and the bench waits exactly that long. Each later slot then appears one falling edge after the one before it. Trap, the dead-slot lookup and the post-flush tag are each sampled on the falling edge right after the edge that acted on them.

// File: rtl/rcb_pkg.sv
// Shared definitions for the reorder buffer.
// Assumes: kind codes are fixed and decoded by the retirement logic.
package rcb_pkg;
    typedef enum logic [1:0] {
        KIND_REG    = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_BRANCH = 2'b10
    } kind_e;
endpackage

// File: rtl/rcb_ptr_ctrl.sv
// Head/tail pointer control with one extra wrap bit each.
// Assumes: DEPTH is a power of two; flush_tag names a live slot.
module rcb_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int PW   = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_fire,
    input  logic            retire_fire,
    input  logic            trap_fire,
    input  logic            flush_fire,
    input  logic [IDXW-1:0] flush_tag,
    output logic [PW-1:0]   head_ptr,
    output logic [PW-1:0]   tail_ptr,
    output logic            full,
    output logic            empty
);
    logic            flush_wrap;
    logic [PW-1:0]   flush_ptr;
    logic [IDXW-1:0] head_idx;

    // Purpose: rebuild the full pointer of the flushed branch slot.
    always_comb begin
        head_idx   = head_ptr[IDXW-1:0];
        flush_wrap = (flush_tag >= head_idx) ? head_ptr[PW-1] : ~head_ptr[PW-1];
        flush_ptr  = {flush_wrap, flush_tag};
        full       = (head_ptr[IDXW-1:0] == tail_ptr[IDXW-1:0]) &&
                     (head_ptr[PW-1] != tail_ptr[PW-1]);
        empty      = (head_ptr == tail_ptr);
    end

    // Purpose: advance head on a clean retirement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            head_ptr <= '0;
        else if (retire_fire)
            head_ptr <= head_ptr + PW'(1);
    end

    // Purpose: move tail on claim, flush rewind or trap collapse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tail_ptr <= '0;
        else if (trap_fire)
            tail_ptr <= head_ptr;
        else if (flush_fire)
            tail_ptr <= flush_ptr + PW'(1);
        else if (alloc_fire)
            tail_ptr <= tail_ptr + PW'(1);
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (PW'(tail_ptr - head_ptr) <= PW'(DEPTH))); // R2
    AST_NO_CLAIM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_fire); // R2
endmodule

// File: rtl/rcb_entry_array.sv
// Per-slot storage: live/ready/fault flags, kind, destination and value.
// Assumes: clear_mask has priority over claim and write-back.
module rcb_entry_array
    import rcb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    parameter int RAW   = 5,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_fire,
    input  logic [IDXW-1:0]           alloc_idx,
    input  kind_e                     alloc_kind,
    input  logic [RAW-1:0]            alloc_dest,
    input  logic                      wb_valid,
    input  logic [IDXW-1:0]           wb_tag,
    input  logic [XLEN-1:0]           wb_value,
    input  logic                      wb_exc,
    input  logic [DEPTH-1:0]          clear_mask,
    output logic [DEPTH-1:0]          valid_vec,
    output logic [DEPTH-1:0]          ready_vec,
    output logic [DEPTH-1:0]          exc_vec,
    output kind_e                     kind_arr  [DEPTH],
    output logic [RAW-1:0]            dest_arr  [DEPTH],
    output logic [XLEN-1:0]           value_arr [DEPTH]
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic claim_here;
        logic wb_here;
        assign claim_here = alloc_fire && (alloc_idx == IDXW'(g));
        assign wb_here    = wb_valid && (wb_tag == IDXW'(g)) && valid_vec[g];

        // Purpose: slot flag lifecycle (claim, result, release).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[g] <= 1'b0;
                ready_vec[g] <= 1'b0;
                exc_vec[g]   <= 1'b0;
            end else if (clear_mask[g]) begin
                valid_vec[g] <= 1'b0;
                ready_vec[g] <= 1'b0;
                exc_vec[g]   <= 1'b0;
            end else if (claim_here) begin
                valid_vec[g] <= 1'b1;
                ready_vec[g] <= 1'b0;
                exc_vec[g]   <= 1'b0;
            end else if (wb_here) begin
                ready_vec[g] <= 1'b1;
                exc_vec[g]   <= wb_exc;
            end
        end

        // Purpose: slot payload (kind, destination, value).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                kind_arr[g]  <= KIND_REG;
                dest_arr[g]  <= '0;
                value_arr[g] <= '0;
            end else if (claim_here && !clear_mask[g]) begin
                kind_arr[g]  <= alloc_kind;
                dest_arr[g]  <= alloc_dest;
            end else if (wb_here && !clear_mask[g]) begin
                value_arr[g] <= wb_value;
            end
        end

        AST_READY_IMPLIES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            ready_vec[g] |-> valid_vec[g]); // R3
    end

    AST_CLAIM_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |-> !valid_vec[alloc_idx]); // R2
endmodule

// File: rtl/rcb_fwd_lookup.sv
// Operand lookup port: reports whether a slot holds its result, and the value.
// Assumes: combinational read of the current slot state, no same-cycle bypass.
module rcb_fwd_lookup #(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic [IDXW-1:0]  lk_tag,
    input  logic [DEPTH-1:0] valid_vec,
    input  logic [DEPTH-1:0] ready_vec,
    input  logic [XLEN-1:0]  value_arr [DEPTH],
    output logic             lk_ready,
    output logic [XLEN-1:0]  lk_value
);
    // Purpose: select the looked-up slot.
    always_comb begin
        lk_ready = valid_vec[lk_tag] && ready_vec[lk_tag];
        lk_value = value_arr[lk_tag];
    end
endmodule

// File: rtl/reorder_commit_buf.sv
// Reorder buffer top: claim, write-back, flush, lookup and in-order retirement.
// Assumes: DEPTH is a power of two; flush_tag refers to a live branch slot;
// retirement outputs are registered one cycle after the head is seen ready.
module reorder_commit_buf
    import rcb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    parameter int RAW   = 5,
    localparam int IDXW = $clog2(DEPTH),
    localparam int PW   = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_req,
    input  logic [1:0]      alloc_kind,
    input  logic [RAW-1:0]  alloc_dest,
    output logic            alloc_ok,
    output logic [IDXW-1:0] alloc_tag,
    input  logic            wb_valid,
    input  logic [IDXW-1:0] wb_tag,
    input  logic [XLEN-1:0] wb_value,
    input  logic            wb_exc,
    input  logic            flush_valid,
    input  logic [IDXW-1:0] flush_tag,
    input  logic [IDXW-1:0] lk_tag,
    output logic            lk_ready,
    output logic [XLEN-1:0] lk_value,
    output logic            rf_we,
    output logic [RAW-1:0]  rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            st_commit,
    output logic            cm_valid,
    output logic [1:0]      cm_kind,
    output logic            trap,
    output logic [IDXW-1:0] trap_tag
);
    logic [PW-1:0]    head_ptr, tail_ptr;
    logic             full, empty;
    logic [IDXW-1:0]  head_idx;
    logic             head_done, trap_fire, retire_fire, flush_fire, alloc_fire;
    logic [IDXW-1:0]  flush_age;
    logic [DEPTH-1:0] clear_mask;
    logic [DEPTH-1:0] valid_vec, ready_vec, exc_vec;
    kind_e            kind_arr  [DEPTH];
    logic [RAW-1:0]   dest_arr  [DEPTH];
    logic [XLEN-1:0]  value_arr [DEPTH];

    // Purpose: retirement, trap and claim decisions for this cycle.
    always_comb begin
        head_idx    = head_ptr[IDXW-1:0];
        head_done   = !empty && valid_vec[head_idx] && ready_vec[head_idx];
        trap_fire   = head_done && exc_vec[head_idx];
        retire_fire = head_done && !exc_vec[head_idx];
        flush_fire  = flush_valid && !trap_fire;
        alloc_ok    = !full && !flush_valid && !trap_fire;
        alloc_fire  = alloc_req && alloc_ok;
        alloc_tag   = tail_ptr[IDXW-1:0];
        flush_age   = flush_tag - head_idx;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_clear
        logic [IDXW-1:0] age_g;
        assign age_g = IDXW'(g) - head_idx;
        assign clear_mask[g] = trap_fire ||
                               (flush_fire && (age_g > flush_age)) ||
                               (retire_fire && (head_idx == IDXW'(g)));
    end

    rcb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_fire  (alloc_fire),
        .retire_fire (retire_fire),
        .trap_fire   (trap_fire),
        .flush_fire  (flush_fire),
        .flush_tag   (flush_tag),
        .head_ptr    (head_ptr),
        .tail_ptr    (tail_ptr),
        .full        (full),
        .empty       (empty)
    );

    rcb_entry_array #(.DEPTH(DEPTH), .XLEN(XLEN), .RAW(RAW)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .alloc_idx  (tail_ptr[IDXW-1:0]),
        .alloc_kind (kind_e'(alloc_kind)),
        .alloc_dest (alloc_dest),
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .wb_value   (wb_value),
        .wb_exc     (wb_exc),
        .clear_mask (clear_mask),
        .valid_vec  (valid_vec),
        .ready_vec  (ready_vec),
        .exc_vec    (exc_vec),
        .kind_arr   (kind_arr),
        .dest_arr   (dest_arr),
        .value_arr  (value_arr)
    );

    rcb_fwd_lookup #(.DEPTH(DEPTH), .XLEN(XLEN)) u_lk (
        .lk_tag    (lk_tag),
        .valid_vec (valid_vec),
        .ready_vec (ready_vec),
        .value_arr (value_arr),
        .lk_ready  (lk_ready),
        .lk_value  (lk_value)
    );

    // Purpose: register the architectural effects of the retiring slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we     <= 1'b0;
            rf_waddr  <= '0;
            rf_wdata  <= '0;
            st_commit <= 1'b0;
            cm_valid  <= 1'b0;
            cm_kind   <= 2'b00;
            trap      <= 1'b0;
            trap_tag  <= '0;
        end else begin
            rf_we     <= retire_fire && (kind_arr[head_idx] == KIND_REG);
            rf_waddr  <= dest_arr[head_idx];
            rf_wdata  <= value_arr[head_idx];
            st_commit <= retire_fire && (kind_arr[head_idx] == KIND_STORE);
            cm_valid  <= retire_fire;
            cm_kind   <= kind_arr[head_idx];
            trap      <= trap_fire;
            trap_tag  <= head_idx;
        end
    end

    AST_RETIRE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        retire_fire |=> (head_ptr == $past(head_ptr) + PW'(1))); // R4
    AST_WRITE_ONLY_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || st_commit) |-> cm_valid); // R6
    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!rf_we && !st_commit && !cm_valid)); // R9
    AST_TRAP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (empty && (valid_vec == '0))); // R9
    AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        flush_fire |=> (tail_ptr[IDXW-1:0] == $past(flush_tag) + IDXW'(1))); // R7
    AST_FLUSH_BLOCKS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> ($past(tail_ptr) != tail_ptr - PW'(1)) || $past(flush_tag) + IDXW'(1) == tail_ptr[IDXW-1:0]); // R7
endmodule

// File: tb/reorder_commit_buf_bench.sv
module reorder_commit_buf_bench;
    localparam int DEPTH = 8;
    localparam int XLEN  = 32;
    localparam int RAW   = 5;
    localparam int IDXW  = 3;

    // {kind[1:0], dest[4:0], value[31:0]}
    localparam logic [38:0] VEC [DEPTH] = '{
        {2'b00, 5'd1, 32'h1111_0001},
        {2'b00, 5'd2, 32'h2222_0002},
        {2'b01, 5'd3, 32'h3333_0003},
        {2'b00, 5'd4, 32'h4444_0004},
        {2'b10, 5'd5, 32'h5555_0005},
        {2'b00, 5'd6, 32'h6666_0006},
        {2'b01, 5'd7, 32'h7777_0007},
        {2'b00, 5'd8, 32'h8888_0008}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            alloc_req;
    logic [1:0]      alloc_kind;
    logic [RAW-1:0]  alloc_dest;
    logic            alloc_ok;
    logic [IDXW-1:0] alloc_tag;
    logic            wb_valid;
    logic [IDXW-1:0] wb_tag;
    logic [XLEN-1:0] wb_value;
    logic            wb_exc;
    logic            flush_valid;
    logic [IDXW-1:0] flush_tag;
    logic [IDXW-1:0] lk_tag;
    logic            lk_ready;
    logic [XLEN-1:0] lk_value;
    logic            rf_we;
    logic [RAW-1:0]  rf_waddr;
    logic [XLEN-1:0] rf_wdata;
    logic            st_commit;
    logic            cm_valid;
    logic [1:0]      cm_kind;
    logic            trap;
    logic [IDXW-1:0] trap_tag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    reorder_commit_buf u_reorder_commit_buf (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_exc(wb_exc),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .lk_tag(lk_tag), .lk_ready(lk_ready), .lk_value(lk_value),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .st_commit(st_commit), .cm_valid(cm_valid), .cm_kind(cm_kind),
        .trap(trap), .trap_tag(trap_tag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alloc_req = 0; alloc_kind = 0; alloc_dest = 0;
        wb_valid = 0; wb_tag = 0; wb_value = 0; wb_exc = 0;
        flush_valid = 0; flush_tag = 0;
    endtask

    // claim one slot now, check the tag, let one edge pass
    task automatic claim(input logic [1:0] k, input logic [4:0] d, input logic [2:0] exp_tag);
        alloc_req = 1; alloc_kind = k; alloc_dest = d;
        #1;
        chk("R2 alloc_ok", 32'(alloc_ok), 1);
        chk("R2 alloc_tag", 32'(alloc_tag), 32'(exp_tag));
        @(negedge clk);
        alloc_req = 0;
    endtask

    task automatic wback(input logic [2:0] t, input logic [31:0] v, input logic e);
        wb_valid = 1; wb_tag = t; wb_value = v; wb_exc = e;
        @(negedge clk);
        wb_valid = 0; wb_exc = 0;
    endtask

    // check the registered retirement outputs for one slot
    task automatic see_retire(input string req, input logic [1:0] k, input logic [4:0] d,
                              input logic [31:0] v);
        chk({req, " cm_valid"}, 32'(cm_valid), 1);
        chk({req, " cm_kind"}, 32'(cm_kind), 32'(k));
        chk({req, " rf_we"}, 32'(rf_we), (k == 2'b00) ? 1 : 0);
        chk({req, " st_commit"}, 32'(st_commit), (k == 2'b01) ? 1 : 0);
        if (k == 2'b00) begin
            chk({req, " rf_waddr"}, 32'(rf_waddr), 32'(d));
            chk({req, " rf_wdata"}, rf_wdata, v);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        lk_tag = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 alloc_ok", 32'(alloc_ok), 1);
        chk("R1 alloc_tag", 32'(alloc_tag), 0);
        chk("R1 rf_we", 32'(rf_we), 0);
        chk("R1 st_commit", 32'(st_commit), 0);
        chk("R1 cm_valid", 32'(cm_valid), 0);
        chk("R1 trap", 32'(trap), 0);
        chk("R1 lk_ready", 32'(lk_ready), 0);
        @(negedge clk);

        // Vector walk: fill, stall on full, write back out of order, drain in order
        for (int i = 0; i < DEPTH; i++)
            claim(VEC[i][38:37], VEC[i][36:32], 3'(i));
        alloc_req = 1; alloc_kind = 2'b00; alloc_dest = 5'd31;
        #1;
        chk("R2 full alloc_ok", 32'(alloc_ok), 0);
        @(negedge clk);
        alloc_req = 0;
        for (int i = DEPTH - 1; i >= 1; i--) begin
            wback(3'(i), VEC[i][31:0], 1'b0);
            chk("R4 no retire behind head", 32'(cm_valid), 0);
            chk("R6 no rf write", 32'(rf_we), 0);
            chk("R6 no store", 32'(st_commit), 0);
        end
        lk_tag = 3'd5;
        #1;
        chk("R3 lk_ready", 32'(lk_ready), 1);
        chk("R3 lk_value", lk_value, VEC[5][31:0]);
        lk_tag = 3'd0;
        #1;
        chk("R3 head not ready", 32'(lk_ready), 0);
        wback(3'd0, VEC[0][31:0], 1'b0);
        chk("R4 one cycle latency", 32'(cm_valid), 0);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            see_retire("R5 R4 drain", VEC[i][38:37], VEC[i][36:32], VEC[i][31:0]);
        end
        @(negedge clk);
        chk("R4 drained", 32'(cm_valid), 0);

        // Flush: head is slot 0 again; branch in slot 1
        claim(2'b00, 5'd11, 3'd0);
        claim(2'b10, 5'd0,  3'd1);
        claim(2'b00, 5'd12, 3'd2);
        claim(2'b00, 5'd13, 3'd3);
        flush_valid = 1; flush_tag = 3'd1; alloc_req = 1;
        #1;
        chk("R7 flush blocks alloc", 32'(alloc_ok), 0);
        @(negedge clk);
        flush_valid = 0; alloc_req = 0;
        wback(3'd2, 32'hDEAD_0002, 1'b0);
        lk_tag = 3'd2;
        #1;
        chk("R7 flushed slot ignores wb", 32'(lk_ready), 0);
        claim(2'b00, 5'd14, 3'd2);
        wback(3'd2, 32'hBEEF_0014, 1'b0);
        wback(3'd1, 32'h0000_0B0B, 1'b0);
        wback(3'd0, 32'hAAAA_0011, 1'b0);
        @(negedge clk);
        see_retire("R7 older slot", 2'b00, 5'd11, 32'hAAAA_0011);
        @(negedge clk);
        see_retire("R7 branch", 2'b10, 5'd0, 32'h0);
        @(negedge clk);
        see_retire("R7 reclaimed slot", 2'b00, 5'd14, 32'hBEEF_0014);
        @(negedge clk);
        chk("R7 nothing beyond", 32'(cm_valid), 0);

        // Deferred fault: slots 3 and 4, fault on 4
        claim(2'b00, 5'd9,  3'd3);
        claim(2'b00, 5'd10, 3'd4);
        wback(3'd4, 32'hFA11_0004, 1'b1);
        repeat (2) begin
            @(negedge clk);
            chk("R8 fault deferred trap", 32'(trap), 0);
            chk("R8 fault deferred cm", 32'(cm_valid), 0);
        end
        wback(3'd3, 32'h0000_0909, 1'b0);
        chk("R8 no trap yet", 32'(trap), 0);
        @(negedge clk);
        see_retire("R8 older retires", 2'b00, 5'd9, 32'h0000_0909);
        chk("R8 no trap with older", 32'(trap), 0);
        @(negedge clk);
        chk("R9 trap", 32'(trap), 1);
        chk("R9 trap_tag", 32'(trap_tag), 4);
        chk("R9 no rf write", 32'(rf_we), 0);
        lk_tag = 3'd4;
        #1;
        chk("R9 slot dead", 32'(lk_ready), 0);
        chk("R9 next tag", 32'(alloc_tag), 4);
        @(negedge clk);
        chk("R9 trap is a pulse", 32'(trap), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule